// File: doc/BRIEF.md
# Strip-Mined Vector Operation Sequencer

This block runs one memory-to-memory vector instruction at a time. The instruction gives an operation (add or multiply), an element count N and three word addresses: two source arrays and one destination array. The sequencer reads both operands, combines them element by element in a small integer ALU, and writes the result array back through a single memory port. That port does one read or one write per cycle. Read data returns one cycle after the read.

The operands pass through an on-chip bank of four register arrays, each L elements long. An instruction longer than L is cut into passes of at most L elements. The last pass carries only the remainder, or a full L when N is a multiple of L. Each pass loads, computes and stores. Three arrays hold the two sources and the result. The fourth array is the spare. While the ALU works on one pass, the next pass's first-operand slice is read into the spare array. After the store, the spare array and the freed first-source array exchange roles. Store traffic always finishes before the next second-operand load starts on the shared port.

Top module: `vec_strip_seq`

## Requirements
- R1: With `op`=0 each result word is `A[i]+B[i]` truncated to W bits and is written to address `base_c+i`.
- R2: With `op`=1 each result word is the low W bits of `A[i]*B[i]`, written to `base_c+i`.
- R3: An instruction performs exactly 2N reads and N writes. Every read address lies in `[base_a, base_a+N)` or `[base_b, base_b+N)`. Writes go out in ascending element order.
- R4: N above L is processed in passes of L elements. The final pass carries N mod L elements, or L when N is an exact multiple of L, and all results are correct at every pass boundary.
- R5: With the overlap parameter set, `busy` stays high for exactly (4c1+1) + Σ over later passes of (3ck+1) + 1 cycles, where ck is the length of pass k. With the parameter clear, each pass costs 4ck+1.
- R6: The memory port never reads and writes in the same cycle.
- R7: `done` is high for exactly one cycle, the cycle after the last write, and `busy` is high from the cycle after `start` up to and including that cycle.
- R8: N=0 raises `done` one cycle after `start` and makes no memory access.
- R9: `start` while `busy` is high is ignored. The running instruction's results, access counts and cycle count are unchanged.
- R10: After reset `busy`, `done`, `mem_re` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| op | input | 1 | 0 = add, 1 = multiply |
| len | input | NW | Element count N |
| base_a | input | AW | First source base address |
| base_b | input | AW | Second source base address |
| base_c | input | AW | Destination base address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid the cycle after `mem_re` |

## Verification
The bench builds the block with L=8 and W=16, keeping the overlap enabled. A short register length lets lengths of 1, 5, 8, 9, 16 and 20 cover these cases: a lone short pass, one exact full pass, a one-element tail, an exact multiple, and a three-pass run with a partial tail. All of them finish in a few hundred cycles. A 16-bit word makes the product wrap in R2 easy to reach with small operands. The exact busy-cycle count shows whether the first-operand load of each later pass was hidden under the previous compute.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_LOAD_A  = 3'd1,
    S_LOAD_B  = 3'd2,
    S_COMPUTE = 3'd3,
    S_STORE   = 3'd4,
    S_DONE    = 3'd5
  } seq_state_t;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } vop_t;
endpackage

// File: rtl/vss_alu.sv
module vss_alu
  import vss_pkg::*;
#(
  parameter int W = 32
) (
  input  vop_t         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  // R1 / R2: element operation, result truncated to W bits
  function automatic logic [W-1:0] elem_op(input vop_t o, input logic [W-1:0] x,
                                           input logic [W-1:0] z);
    logic [2*W-1:0] prod;
    prod = x * z;
    if (o == OP_MUL) return prod[W-1:0];
    else             return x + z;
  endfunction

  always_comb y = elem_op(op, a, b);
endmodule

// File: rtl/vss_bank.sv
module vss_bank #(
  parameter int W    = 32,
  parameter int L    = 64,
  parameter int NARR = 4,
  localparam int IW  = (L > 1) ? $clog2(L) : 1,
  localparam int PW  = (NARR > 1) ? $clog2(NARR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [PW-1:0] ld_arr,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic          cw_we,
  input  logic [PW-1:0] cw_arr,
  input  logic [IW-1:0] cw_idx,
  input  logic [W-1:0]  cw_data,
  input  logic [PW-1:0] ra_arr,
  input  logic [PW-1:0] rb_arr,
  input  logic [PW-1:0] rc_arr,
  input  logic [IW-1:0] r_idx,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data,
  output logic [W-1:0]  rc_data
);
  logic [W-1:0] sel_a [NARR];
  logic [W-1:0] sel_b [NARR];
  logic [W-1:0] sel_c [NARR];

  for (genvar g = 0; g < NARR; g++) begin : g_arr
    logic [W-1:0] cells [L];
    always_ff @(posedge clk) begin
      if (cw_we && cw_arr == PW'(g))      cells[cw_idx] <= cw_data;
      else if (ld_we && ld_arr == PW'(g)) cells[ld_idx] <= ld_data;
    end
    assign sel_a[g] = cells[r_idx];
    assign sel_b[g] = cells[r_idx];
    assign sel_c[g] = cells[r_idx];
  end

  assign ra_data = sel_a[ra_arr];
  assign rb_data = sel_b[rb_arr];
  assign rc_data = sel_c[rc_arr];

  // R5: load returns and ALU results never land in the same array in one cycle
  a_r5_no_array_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we && cw_we && ld_arr == cw_arr));
endmodule

// File: rtl/vec_strip_seq.sv
module vec_strip_seq
  import vss_pkg::*;
#(
  parameter int W       = 32,
  parameter int AW      = 16,
  parameter int NW      = 16,
  parameter int L       = 64,
  parameter bit OVERLAP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op,
  input  logic [NW-1:0] len,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  output logic          busy,
  output logic          done,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata
);
  localparam int CW = $clog2(L + 1);
  localparam int IW = (L > 1) ? $clog2(L) : 1;

  // elements in the pass that starts with r elements still to do
  function automatic logic [CW-1:0] pass_len(input logic [NW-1:0] r);
    if (r >= NW'(L)) return CW'(L);
    else             return CW'(r);
  endfunction

  // word address of element i of a pass at offset off
  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] base,
                                              input logic [AW-1:0] off,
                                              input logic [CW-1:0] i);
    return base + off + AW'(i);
  endfunction

  seq_state_t    state_q;
  vop_t          op_q;
  logic [NW-1:0] rem_q;
  logic [AW-1:0] off_q, a_q, b_q, c_q;
  logic [1:0]    pa_q, pb_q, pr_q, ps_q;
  logic [CW-1:0] idx_q, pf_idx_q;
  logic          rv_q;
  logic [1:0]    rarr_q;
  logic [IW-1:0] ridx_q;

  // named internal events
  logic [CW-1:0] cur_len, nxt_len;
  logic [NW-1:0] nxt_rem;
  logic          has_next, last_elem, ld_hazard, comp_fire, pf_want, zero_start;
  logic          take_start, rd_issue;
  logic [1:0]    rd_arr;
  logic [CW-1:0] rd_idx;
  logic [W-1:0]  ra_data, rb_data, rc_data, alu_y;

  always_comb begin
    cur_len    = pass_len(rem_q);
    nxt_rem    = rem_q - NW'(cur_len);
    nxt_len    = pass_len(nxt_rem);
    has_next   = (nxt_rem != '0);
    last_elem  = (idx_q == cur_len - CW'(1));
    ld_hazard  = rv_q && (rarr_q == pa_q || rarr_q == pb_q);
    comp_fire  = (state_q == S_COMPUTE) && !ld_hazard;
    pf_want    = OVERLAP && (state_q == S_COMPUTE) && has_next && (pf_idx_q < nxt_len);
    take_start = (state_q == S_IDLE) && start;
    zero_start = take_start && (len == '0);
  end

  // memory port: one access per cycle, selected by state
  always_comb begin
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    rd_arr   = pa_q;
    rd_idx   = idx_q;
    unique case (state_q)
      S_LOAD_A: begin
        mem_re   = 1'b1;
        mem_addr = elem_addr(a_q, off_q, idx_q);
      end
      S_LOAD_B: begin
        mem_re   = 1'b1;
        mem_addr = elem_addr(b_q, off_q, idx_q);
        rd_arr   = pb_q;
      end
      S_COMPUTE: begin
        mem_re   = pf_want;
        mem_addr = elem_addr(a_q, off_q + AW'(L), pf_idx_q);
        rd_arr   = ps_q;
        rd_idx   = pf_idx_q;
      end
      S_STORE: begin
        mem_we   = 1'b1;
        mem_addr = elem_addr(c_q, off_q, idx_q);
      end
      default: ;
    endcase
    rd_issue = mem_re;
  end

  assign mem_wdata = rc_data;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);

  // read-return pipeline (one cycle latency)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      rarr_q <= '0;
      ridx_q <= '0;
    end else begin
      rv_q   <= rd_issue;
      rarr_q <= rd_arr;
      ridx_q <= IW'(rd_idx);
    end
  end

  vss_bank #(.W(W), .L(L), .NARR(4)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (rv_q),
    .ld_arr  (rarr_q),
    .ld_idx  (ridx_q),
    .ld_data (mem_rdata),
    .cw_we   (comp_fire),
    .cw_arr  (pr_q),
    .cw_idx  (IW'(idx_q)),
    .cw_data (alu_y),
    .ra_arr  (pa_q),
    .rb_arr  (pb_q),
    .rc_arr  (pr_q),
    .r_idx   (IW'(idx_q)),
    .ra_data (ra_data),
    .rb_data (rb_data),
    .rc_data (rc_data)
  );

  vss_alu #(.W(W)) u_alu (
    .op (op_q),
    .a  (ra_data),
    .b  (rb_data),
    .y  (alu_y)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_ADD;
      rem_q    <= '0;
      off_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      pa_q     <= 2'd0;
      pb_q     <= 2'd1;
      pr_q     <= 2'd2;
      ps_q     <= 2'd3;
      idx_q    <= '0;
      pf_idx_q <= '0;
    end else begin
      if (pf_want) pf_idx_q <= pf_idx_q + CW'(1);
      unique case (state_q)
        S_IDLE: if (take_start) begin
          op_q     <= vop_t'(op);
          rem_q    <= len;
          off_q    <= '0;
          a_q      <= base_a;
          b_q      <= base_b;
          c_q      <= base_c;
          pa_q     <= 2'd0;
          pb_q     <= 2'd1;
          pr_q     <= 2'd2;
          ps_q     <= 2'd3;
          idx_q    <= '0;
          pf_idx_q <= '0;
          state_q  <= zero_start ? S_DONE : S_LOAD_A;
        end
        S_LOAD_A, S_LOAD_B: begin
          if (last_elem) begin
            idx_q   <= '0;
            state_q <= (state_q == S_LOAD_A) ? S_LOAD_B : S_COMPUTE;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        S_COMPUTE: if (comp_fire) begin
          if (last_elem) begin
            idx_q   <= '0;
            state_q <= S_STORE;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        S_STORE: begin
          if (last_elem) begin
            idx_q <= '0;
            if (has_next) begin
              rem_q    <= nxt_rem;
              off_q    <= off_q + AW'(L);
              pf_idx_q <= '0;
              if (OVERLAP) begin
                pa_q    <= ps_q;   // prefetched slice becomes the first source
                ps_q    <= pa_q;   // old first source becomes the spare
                state_q <= S_LOAD_B;
              end else begin
                state_q <= S_LOAD_A;
              end
            end else begin
              state_q <= S_DONE;
            end
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r6_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !mem_we) |=> !done);

  a_r8_zero_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (done && !mem_re && !mem_we));

  a_r9_inst_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(op_q)));

  a_r5_prefetch_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_fire && last_elem && has_next && OVERLAP)
      |-> ((pf_idx_q + CW'(pf_want)) >= nxt_len));

  a_r4_pass_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> (cur_len != '0));
endmodule

// File: tb/vec_strip_seq_test.sv
module vec_strip_seq_test;
  localparam int W  = 16;
  localparam int AW = 16;
  localparam int NW = 12;
  localparam int L  = 8;
  localparam int MW = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op = 1'b0;
  logic [NW-1:0] len = '0;
  logic [AW-1:0] base_a = '0, base_b = '0, base_c = '0;
  logic          busy, done, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  vec_strip_seq #(.W(W), .AW(AW), .NW(NW), .L(L), .OVERLAP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .len(len),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .busy(busy), .done(done), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  // memory model
  logic [W-1:0] mem [MW];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  end

  int tests = 0, fails = 0;
  logic [AW+W-1:0] exp_q [$];
  int rd_cnt, rd_bad, busy_cnt, done_cnt, clash_cnt;
  int cur_n;
  logic [AW-1:0] cur_a, cur_b;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write", longint'(mem_addr), -1);
        end else begin
          logic [AW+W-1:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata} == e, "R1/R2/R4 write addr:data",
              longint'({mem_addr, mem_wdata}), longint'(e));
        end
      end
      if (mem_re) begin
        rd_cnt++;
        if (!((mem_addr >= cur_a && mem_addr < cur_a + AW'(cur_n)) ||
              (mem_addr >= cur_b && mem_addr < cur_b + AW'(cur_n)))) rd_bad++;
      end
      if (mem_re && mem_we) clash_cnt++;
      if (busy) busy_cnt++;
      if (done) done_cnt++;
    end
  end

  function automatic int exp_cycles(input int n);
    int r, k, c, t;
    r = n; k = 0; t = 1;
    while (r > 0) begin
      c = (r > L) ? L : r;
      t += (k == 0) ? (4 * c + 1) : (3 * c + 1);
      r -= c; k++;
    end
    return t;
  endfunction

  task automatic run_vec(input bit o, input int n, input int a, input int b, input int c,
                         input int seed, input bit poke);
    cur_n = n; cur_a = AW'(a); cur_b = AW'(b);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] x, y, r;
      logic [2*W-1:0] p;
      x = W'(seed * 37 + i * 1013 + 7);
      y = W'(seed * 11 + i * 257 + 300);
      mem[a + i] = x;
      mem[b + i] = y;
      p = x * y;
      r = o ? p[W-1:0] : W'(x + y);
      exp_q.push_back({AW'(c + i), r});
    end
    rd_cnt = 0; rd_bad = 0; busy_cnt = 0; done_cnt = 0; clash_cnt = 0;
    @(negedge clk);
    op = o; len = NW'(n); base_a = AW'(a); base_b = AW'(b); base_c = AW'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      op = ~o; len = NW'(3); base_a = AW'(900); base_b = AW'(910); base_c = AW'(a);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    exp_q.delete();
    chk(rd_cnt == 2 * n, "R3 read count", rd_cnt, 2 * n);
    chk(rd_bad == 0, "R3 read address range", rd_bad, 0);
    chk(busy_cnt == exp_cycles(n), poke ? "R9 busy cycles with ignored start" : "R5 busy cycles",
        busy_cnt, exp_cycles(n));
    chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
    chk(clash_cnt == 0, "R6 read/write clash", clash_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R10 reset outputs",
        {busy, done, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    run_vec(1'b0, 5,  0,   100, 200, 1, 1'b0);  // R1 single short pass
    run_vec(1'b1, 8,  10,  110, 210, 2, 1'b0);  // R2 one exact full pass
    run_vec(1'b0, 20, 20,  120, 230, 3, 1'b0);  // R4 three passes, partial tail
    run_vec(1'b1, 16, 50,  150, 260, 4, 1'b0);  // R4 exact multiple
    run_vec(1'b0, 9,  70,  170, 290, 5, 1'b0);  // R4 one-element tail
    run_vec(1'b1, 1,  80,  180, 300, 6, 1'b0);  // single element
    run_vec(1'b0, 0,  0,   0,   400, 7, 1'b0);  // R8 zero length
    run_vec(1'b1, 17, 500, 600, 700, 8, 1'b1);  // R9 start ignored while busy
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule